// File: doc/BRIEF.md
# Oscillator Start-Up Delay Sequencer

This block keeps the processor core held in reset after a start-up event and lets it go only once the delays that suit the clock source have run out. The possible events are power-up, brown-out, wake-up from sleep and a clock-source switch. The clock source can be a crystal, a crystal followed by a x4 multiplier PLL, an external clock or an external RC network. A power-up timer is available, and its enable is active low.

When an event pulse arrives, the block latches the event kind, the clock mode and the timer enable. From these it works out which delay stages apply. There are up to four stages: a long power-up wait, an oscillator-period start-up count, a PLL lock wait and a short sleep-recovery wait. The stages always run in that fixed order, and each is counted in clock cycles. The block reports busy while a sequence is in progress. It raises the release output one cycle after the last stage ends. A new event arriving during a sequence starts the sequence again from the beginning, using the new inputs.

Each stage length is a parameter, so a testbench or a faster system can shorten the delays. The analog parts (oscillator, PLL and brown-out detector) are not modelled. Their effect reaches the block only as event pulses on a free-running clock.

Top module: `osc_start_seq`

## Requirements
- R1: After reset, `core_release` and `busy` are both low. Both stay low until the first event pulse.
- R2: When `evt_valid` is high at a clock edge, the next cycle has `core_release` low and `busy` high. They stay that way until T+1 edges after the event, where T is the sum of the lengths of the selected stages. At that point `core_release` goes high and `busy` goes low.
- R3: The event code is on `evt_kind`: 0 = power-up, 1 = brown-out, 2 = wake-up from sleep, 3 = clock-source switch. The mode code is on `osc_mode`: 0 = crystal, 1 = crystal with PLL, 2 = external clock, 3 = external RC. For power-up with `pwrt_en_n` = 0 in crystal mode, T = PWRT_CYC + OST_CYC.
- R4: When `pwrt_en_n` = 1, power-up skips the power-up wait. Crystal mode then gives T = OST_CYC. External modes give T = 0, so release comes one cycle after the event.
- R5: In mode 1, a PLL lock wait of PLL_CYC follows the start-up count for every event kind.
- R6: Modes 2 and 3 never apply the start-up count. On power-up they apply only the power-up wait, and only if it is enabled.
- R7: A brown-out always applies the power-up wait, whatever `pwrt_en_n` is. The mode-dependent stages follow it.
- R8: Wake-up applies the start-up count in modes 0 and 1, with the PLL wait added in mode 1. In mode 2 it applies only RECOV_CYC. In mode 3 it applies no delay.
- R9: A clock-source switch applies the start-up count in modes 0 and 1, with the PLL wait added in mode 1. In modes 2 and 3 it applies no delay.
- R10: An event that arrives while a sequence is running starts over from the first stage selected by the new inputs. The timing is counted from the new event.
- R11: Once `core_release` is high, it stays high until the next event pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| evt_valid | input | 1 | One-cycle pulse marking a start-up event |
| evt_kind | input | 2 | Event code sampled with `evt_valid` |
| osc_mode | input | 2 | Clock-source mode sampled with `evt_valid` |
| pwrt_en_n | input | 1 | Active-low power-up timer enable sampled with `evt_valid` |
| core_release | output | 1 | High when the core may run |
| busy | output | 1 | High while a delay sequence is in progress |

## Verification
The hardest case to reach is a restart partway through a stage. The old stage counter must be dropped, and the new plan must begin from its own first stage, not carry on from where the old plan stopped. To reach it, the bench starts a long power-up sequence and fires a wake-up event with a different mode in the middle of the power-up wait. It then times the release purely from the second pulse. Sequences whose plan is empty are also covered, because they reach the finish cycle without running any counter.

// File: rtl/osc_start_pkg.sv
package osc_start_pkg;

  localparam int NSTG = 4;
  localparam int STG_PWRT  = 0;
  localparam int STG_OST   = 1;
  localparam int STG_PLL   = 2;
  localparam int STG_RECOV = 3;

  typedef enum logic [1:0] {
    EVT_POWER  = 2'd0,
    EVT_BROWN  = 2'd1,
    EVT_WAKE   = 2'd2,
    EVT_SWITCH = 2'd3
  } evt_kind_e;

  typedef enum logic [1:0] {
    MODE_XTAL     = 2'd0,
    MODE_XTAL_PLL = 2'd1,
    MODE_EXT_CLK  = 2'd2,
    MODE_EXT_RC   = 2'd3
  } osc_mode_e;

  typedef enum logic [1:0] {
    PH_HOLD, PH_RUN, PH_FINISH, PH_IDLE
  } phase_e;

  // Which stages an event needs, one bit per stage index.
  function automatic logic [NSTG-1:0] plan_mask(input logic [1:0] kind,
                                                input logic [1:0] mode,
                                                input logic       en_n);
    logic [NSTG-1:0] m;
    logic xtal, pll;
    m    = '0;
    xtal = (mode == MODE_XTAL) || (mode == MODE_XTAL_PLL);
    pll  = (mode == MODE_XTAL_PLL);
    m[STG_OST] = xtal;
    m[STG_PLL] = pll;
    case (kind)
      EVT_POWER: m[STG_PWRT]  = !en_n;
      EVT_BROWN: m[STG_PWRT]  = 1'b1;
      EVT_WAKE:  m[STG_RECOV] = (mode == MODE_EXT_CLK);
      default:   ;
    endcase
    return m;
  endfunction

  // Lowest selected stage at or above 'from'; bit 2 set means none left.
  function automatic logic [2:0] next_stage(input logic [NSTG-1:0] mask,
                                            input logic [2:0]      from);
    logic [2:0] r;
    logic found;
    r = 3'd4;
    found = 1'b0;
    for (int i = 0; i < NSTG; i++) begin
      if (!found && (3'(i) >= from) && mask[i]) begin
        r = 3'(i);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/osc_start_plan.sv
module osc_start_plan
  import osc_start_pkg::*;
(
  input  logic [1:0]      evt_kind,
  input  logic [1:0]      osc_mode,
  input  logic            pwrt_en_n,
  output logic [NSTG-1:0] mask,
  output logic [2:0]      first
);
  always_comb begin
    mask  = plan_mask(evt_kind, osc_mode, pwrt_en_n);
    first = next_stage(mask, 3'd0);
  end
endmodule

// File: rtl/osc_start_tmr.sv
module osc_start_tmr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          last
);
  logic [CW-1:0] cnt;

  assign last = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/osc_start_seq.sv
module osc_start_seq
  import osc_start_pkg::*;
#(
  parameter int PWRT_CYC  = 288000,
  parameter int OST_CYC   = 1024,
  parameter int PLL_CYC   = 8000,
  parameter int RECOV_CYC = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_valid,
  input  logic [1:0] evt_kind,
  input  logic [1:0] osc_mode,
  input  logic       pwrt_en_n,
  output logic       core_release,
  output logic       busy
);
  localparam int MAXLEN = max4(PWRT_CYC, OST_CYC, PLL_CYC, RECOV_CYC);
  localparam int CW     = $clog2(MAXLEN) + 1;

  function automatic logic [CW-1:0] stage_limit(input logic [1:0] idx);
    int n;
    case (idx)
      2'd0:    n = PWRT_CYC;
      2'd1:    n = OST_CYC;
      2'd2:    n = PLL_CYC;
      default: n = RECOV_CYC;
    endcase
    return CW'(n - 1);
  endfunction

  phase_e          phase;
  logic [NSTG-1:0] mask_q;
  logic [1:0]      sel;
  logic [NSTG-1:0] new_mask;
  logic [2:0]      new_first;
  logic [2:0]      after;

  // Named internal events
  logic evt_start, stage_done, seq_done;

  osc_start_plan plan_i (
    .evt_kind (evt_kind),
    .osc_mode (osc_mode),
    .pwrt_en_n(pwrt_en_n),
    .mask     (new_mask),
    .first    (new_first)
  );

  osc_start_tmr #(.CW(CW)) tmr_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(evt_start || stage_done),
    .run  (phase == PH_RUN),
    .limit(stage_limit(sel)),
    .last (stage_done)
  );

  assign evt_start = evt_valid;
  assign seq_done  = (phase == PH_FINISH);
  assign after     = next_stage(mask_q, {1'b0, sel} + 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_HOLD;
      mask_q <= '0;
      sel    <= '0;
    end else if (evt_start) begin
      mask_q <= new_mask;
      if (new_first[2]) phase <= PH_FINISH;
      else begin
        phase <= PH_RUN;
        sel   <= new_first[1:0];
      end
    end else begin
      case (phase)
        PH_RUN: if (stage_done) begin
          if (after[2]) phase <= PH_FINISH;
          else          sel   <= after[1:0];
        end
        PH_FINISH: phase <= PH_IDLE;
        default: ;
      endcase
    end
  end

  assign core_release = (phase == PH_IDLE);
  assign busy         = (phase == PH_RUN) || (phase == PH_FINISH);
endmodule

// File: rtl/osc_start_seq_chk.sv
module osc_start_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic evt_valid,
  input logic core_release,
  input logic busy,
  input logic stage_done,
  input logic seq_done
);
  assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_release && busy));

  assert_evt_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> (!core_release && busy));

  assert_done_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !evt_valid) |=> core_release);

  assert_stage_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stage_done |-> busy);

  assert_restart_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && evt_valid) |=> busy);

  assert_release_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (core_release && !evt_valid) |=> core_release);
endmodule

bind osc_start_seq osc_start_seq_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_valid   (evt_valid),
  .core_release(core_release),
  .busy        (busy),
  .stage_done  (stage_done),
  .seq_done    (seq_done)
);

// File: tb/osc_start_seq_tb_top.sv
module osc_start_seq_tb_top;
  localparam int P_PWRT = 20;
  localparam int P_OST  = 8;
  localparam int P_PLL  = 5;
  localparam int P_REC  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 1'b0;
  logic [1:0] evt_kind = '0;
  logic [1:0] osc_mode = '0;
  logic pwrt_en_n = 1'b0;
  logic core_release, busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  osc_start_seq #(
    .PWRT_CYC(P_PWRT), .OST_CYC(P_OST), .PLL_CYC(P_PLL), .RECOV_CYC(P_REC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .osc_mode(osc_mode), .pwrt_en_n(pwrt_en_n),
    .core_release(core_release), .busy(busy)
  );

  // Expected total delay, restated from the requirement list.
  function automatic int exp_len(input int kind, input int mode, input int en_n);
    int t;
    bit crystal;
    t = 0;
    crystal = (mode < 2);
    if (kind == 1 || (kind == 0 && en_n == 0)) t += P_PWRT;  // R3 R7
    if (crystal) t += P_OST;                                  // R6 R8 R9
    if (mode == 1) t += P_PLL;                                // R5
    if (kind == 2 && mode == 2) t += P_REC;                   // R8
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fire(input int kind, input int mode, input int en_n);
    @(negedge clk);
    evt_kind  = 2'(kind);
    osc_mode  = 2'(mode);
    pwrt_en_n = en_n[0];
    evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  // Called right after the negedge that follows the event edge.
  task automatic expect_timing(input int t, input string req);
    int bad_at;
    bad_at = -1;
    for (int j = 0; j <= t; j++) begin
      if ((core_release || !busy) && bad_at < 0) bad_at = j;
      @(negedge clk);
    end
    check(bad_at < 0, {req, " held"}, bad_at, -1);
    check(core_release && !busy, {req, " release"},
          int'({core_release, busy}), 2);
  endtask

  task automatic run_case(input int kind, input int mode, input int en_n, input string req);
    fire(kind, mode, en_n);
    expect_timing(exp_len(kind, mode, en_n), req);
  endtask

  task automatic test_reset_r1;
    repeat (5) @(negedge clk);
    check(!core_release && !busy, "R1", int'({core_release, busy}), 0);
  endtask

  task automatic test_power_r3_r4_r6;
    run_case(0, 0, 0, "R3 power xtal en");
    run_case(0, 0, 1, "R4 power xtal dis");
    run_case(0, 2, 1, "R4 power extclk dis");
    run_case(0, 3, 1, "R4 power extrc dis");
    run_case(0, 2, 0, "R6 power extclk en");
    run_case(0, 3, 0, "R6 power extrc en");
  endtask

  task automatic test_pll_r5;
    run_case(0, 1, 0, "R5 power pll");
    run_case(1, 1, 1, "R5 brown pll");
    run_case(2, 1, 0, "R5 wake pll");
    run_case(3, 1, 0, "R5 switch pll");
  endtask

  task automatic test_brown_r7;
    run_case(1, 0, 1, "R7 brown xtal dis");
    run_case(1, 3, 0, "R7 brown extrc");
    run_case(1, 2, 1, "R7 brown extclk");
  endtask

  task automatic test_wake_r8;
    run_case(2, 0, 0, "R8 wake xtal");
    run_case(2, 2, 0, "R8 wake extclk");
    run_case(2, 3, 0, "R8 wake extrc");
  endtask

  task automatic test_switch_r9;
    run_case(3, 0, 1, "R9 switch xtal");
    run_case(3, 2, 0, "R9 switch extclk");
    run_case(3, 3, 0, "R9 switch extrc");
  endtask

  task automatic test_restart_r10;
    fire(0, 0, 0);
    repeat (7) @(negedge clk);
    run_case(2, 1, 0, "R10 restart mid pwrt");
    fire(1, 1, 0);
    repeat (P_PWRT + 2) @(negedge clk);
    run_case(3, 2, 0, "R10 restart to empty");
  endtask

  task automatic test_sticky_r11;
    int drop;
    drop = 0;
    for (int j = 0; j < 40; j++) begin
      if (!core_release) drop++;
      @(negedge clk);
    end
    check(drop == 0, "R11", drop, 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset_r1();
    test_power_r3_r4_r6();
    test_pll_r5();
    test_brown_r7();
    test_wake_r8();
    test_switch_r9();
    test_restart_r10();
    test_sticky_r11();
    finish_run();
  end
endmodule